// File: doc/BRIEF.md
# Wake-Up Frame Pattern Filter Bank

This block sits beside a receive byte stream and decides, frame by frame, whether an incoming Ethernet frame should wake the system. It holds four independent pattern filters. Each filter is programmed with a 31-bit byte-select mask, an 8-bit starting offset, a command word and an expected CRC-16. While a frame streams in, every filter runs a CRC-16 over only the frame bytes its mask picks out, starting at its offset. When the last byte arrives, each filter compares its result with the programmed value and checks the destination address class.

Software programs the filters through a small write port that addresses one field of one filter at a time. Written values land in a staging copy and are adopted by the filters on the next frame start, so a write never disturbs a frame in flight. One cycle after the last byte of a frame, the block raises one match flag per filter that accepted the frame, together with a single-cycle wake pulse when any filter accepted it.

Top module: `wkp_filter_bank`

## Requirements
- R1: After reset every filter is disabled, and `match_o` and `wake_o` are low; a frame sent before any write produces no match.
- R2: A filter whose enable bit (command bit 0) is clear never reports a match, even when its CRC and address class agree.
- R3: An enabled filter computes a CRC-16 with polynomial 0x8005, seeded with 0xFFFF at frame start, feeding each selected byte least significant bit first; it matches when the result equals its expected value (written field 3, bits 15:0).
- R4: Mask bit j (written field 0, bits 30:0) selects frame byte offset + j for the CRC; a byte whose mask bit is clear does not affect the result.
- R5: The offset (written field 1, bits 7:0) counts from the first byte of the frame, the first destination address byte, which has position 0.
- R6: With command bit 3 set a filter accepts only frames whose first byte has bit 0 set (multicast); with it clear only frames whose first byte has bit 0 clear (unicast).
- R7: A frame that ends before the byte selected by the highest set mask bit does not match on that filter.
- R8: A write (filter index on `wr_idx_i`, field on `wr_fld_i`) takes effect from the next frame start; a write during a frame does not change that frame's decision.
- R9: `match_o` bit i and `wake_o` are single-cycle pulses in the cycle after the last-byte strobe; `wake_o` is high exactly when at least one match bit is high.
- R10: Mask bit 31 and command bits 2:1 are ignored.
- R11: A filter with an all-zero mask keeps the CRC at 0xFFFF and matches when its expected value is 0xFFFF.
- R12: Cycles with `rx_valid_i` low do not advance the byte position or feed the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Marks the first byte of a frame (with valid) |
| rx_eof_i | input | 1 | Marks the last byte of a frame (with valid) |
| rx_data_i | input | 8 | Receive byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 2 | Filter index of the write |
| wr_fld_i | input | 2 | Field select: 0 mask, 1 offset, 2 command, 3 expected CRC |
| wr_data_i | input | 32 | Write data |
| match_o | output | 4 | Per-filter match pulse |
| wake_o | output | 1 | Wake pulse, any filter matched |

## Verification
Every internal fault of this block surfaces only at one point in time: the cycle after a frame's last-byte strobe, as a missing or spurious match bit or wake pulse. A corrupted CRC register, byte position or completion flag stays invisible through the whole frame and appears only at its end, so the directed frames are built to make each masked byte, each skipped byte and each boundary position decide the outcome. A staging fault, such as configuration adopted too early or too late, shows on the frame after the write, which is why the write-timing scenario sends two frames back to back.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    localparam int NUM_FILT = 4;
    localparam int MASK_W   = 31;
    localparam int OFS_W    = 8;
    localparam int CRC_W    = 16;
    localparam int REG_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = $clog2(NUM_FILT);
    localparam int REL_W    = $clog2(MASK_W);
    localparam int POS_W    = OFS_W + 2;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    localparam int CMD_EN_BIT = 0;
    localparam int CMD_MC_BIT = 3;

    typedef enum logic [1:0] {
        FLD_MASK = 2'd0,
        FLD_OFS  = 2'd1,
        FLD_CMD  = 2'd2,
        FLD_CRC  = 2'd3
    } fld_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [OFS_W-1:0]  ofs;
        logic              en;
        logic              mcast;
        logic [CRC_W-1:0]  crc;
    } filt_cfg_t;

    typedef struct packed {
        logic              vld;
        logic              sof;
        logic              eof;
        logic              mcast;
        logic [POS_W-1:0]  pos;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    // One byte through the CRC, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

    // Index of the highest set mask bit (0 when the mask is empty).
    function automatic logic [REL_W-1:0] top_bit(input logic [MASK_W-1:0] m);
        logic [REL_W-1:0] t;
        t = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i]) t = REL_W'(i);
        end
        return t;
    endfunction

endpackage

// File: rtl/wkp_cfg_regs.sv
module wkp_cfg_regs
    import wkp_pkg::*;
#(
    parameter int N = NUM_FILT
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  fld_e                wr_fld_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic                frame_start_i,
    output filt_cfg_t           stage_o [N],
    output filt_cfg_t           live_o  [N]
);

    logic unused_bits;
    assign unused_bits = ^{wr_data_i[REG_W-1:MASK_W], wr_data_i[2:1]};

    for (genvar g = 0; g < N; g++) begin : g_slot
        filt_cfg_t stage_q, live_q;
        logic      hit_slot;

        assign hit_slot = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q <= '0;
            end else if (hit_slot) begin
                case (wr_fld_i)
                    FLD_MASK: stage_q.mask <= wr_data_i[MASK_W-1:0];
                    FLD_OFS:  stage_q.ofs  <= wr_data_i[OFS_W-1:0];
                    FLD_CMD: begin
                        stage_q.en    <= wr_data_i[CMD_EN_BIT];
                        stage_q.mcast <= wr_data_i[CMD_MC_BIT];
                    end
                    FLD_CRC:  stage_q.crc  <= wr_data_i[CRC_W-1:0];
                    default:  stage_q      <= stage_q;
                endcase
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                live_q <= '0;
            end else if (frame_start_i) begin
                live_q <= stage_q;
            end
        end

        assign stage_o[g] = stage_q;
        assign live_o[g]  = live_q;
    end

endmodule

// File: rtl/wkp_frame_track.sv
module wkp_frame_track
    import wkp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_valid_i,
    input  logic              rx_sof_i,
    input  logic              rx_eof_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    output rx_beat_t          beat_o,
    output logic              frame_start_o
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             in_frame_q;
    logic [POS_W-1:0] pos_q;
    logic             mc_q;
    logic             take;
    logic [POS_W-1:0] pos_cur;
    logic             mc_cur;

    assign take    = rx_valid_i && (rx_sof_i || in_frame_q);
    assign pos_cur = rx_sof_i ? '0 : pos_q;
    assign mc_cur  = rx_sof_i ? rx_data_i[0] : mc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            in_frame_q <= 1'b0;
            pos_q      <= '0;
            mc_q       <= 1'b0;
        end else if (take) begin
            in_frame_q <= !rx_eof_i;
            pos_q      <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
            mc_q       <= mc_cur;
        end
    end

    always_comb begin
        beat_o.vld   = take;
        beat_o.sof   = rx_valid_i && rx_sof_i;
        beat_o.eof   = rx_eof_i;
        beat_o.mcast = mc_cur;
        beat_o.pos   = pos_cur;
        beat_o.data  = rx_data_i;
    end

    assign frame_start_o = rx_valid_i && rx_sof_i;

endmodule

// File: rtl/wkp_filter.sv
module wkp_filter
    import wkp_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  rx_beat_t  beat_i,
    input  filt_cfg_t cfg_i,
    output logic      accept_o
);

    logic [CRC_W-1:0] crc_q, crc_cur, crc_nx;
    logic             done_q, done_cur, done_nx;
    logic [POS_W:0]   rel_full;
    logic [REL_W-1:0] rel;
    logic [MASK_W:0]  mask_ext;
    logic             in_win;
    logic             sel;

    assign rel_full = {1'b0, beat_i.pos} - (POS_W+1)'(cfg_i.ofs);
    assign in_win   = !rel_full[POS_W] && (rel_full < (POS_W+1)'(MASK_W));
    assign rel      = rel_full[REL_W-1:0];
    assign mask_ext = {1'b0, cfg_i.mask};
    assign sel      = beat_i.vld && in_win && mask_ext[rel];

    assign crc_cur  = beat_i.sof ? CRC_SEED : crc_q;
    assign done_cur = beat_i.sof ? (cfg_i.mask == '0) : done_q;
    assign crc_nx   = sel ? crc_step(crc_cur, beat_i.data) : crc_cur;
    assign done_nx  = done_cur || (sel && (rel == top_bit(cfg_i.mask)));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            crc_q  <= CRC_SEED;
            done_q <= 1'b0;
        end else if (beat_i.vld) begin
            crc_q  <= crc_nx;
            done_q <= done_nx;
        end
    end

    assign accept_o = beat_i.vld && beat_i.eof && cfg_i.en && done_nx
                   && (crc_nx == cfg_i.crc) && (cfg_i.mcast == beat_i.mcast);

endmodule

// File: rtl/wkp_filter_bank.sv
module wkp_filter_bank
    import wkp_pkg::*;
#(
    parameter int N = NUM_FILT
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_valid_i,
    input  logic              rx_sof_i,
    input  logic              rx_eof_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [1:0]        wr_fld_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [N-1:0]      match_o,
    output logic              wake_o
);

    rx_beat_t  beat;
    logic      frame_start;
    filt_cfg_t stage [N];
    filt_cfg_t live  [N];
    filt_cfg_t cfg_eff [N];
    logic [N-1:0] accept;
    logic [N-1:0] eff_en;
    logic [N-1:0] eff_mc;
    logic         beat_mc;
    logic [N-1:0] match_q;
    logic         wake_q;

    wkp_frame_track u_track (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .rx_valid_i    (rx_valid_i),
        .rx_sof_i      (rx_sof_i),
        .rx_eof_i      (rx_eof_i),
        .rx_data_i     (rx_data_i),
        .beat_o        (beat),
        .frame_start_o (frame_start)
    );

    wkp_cfg_regs #(.N(N)) u_regs (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .wr_en_i       (wr_en_i),
        .wr_idx_i      (wr_idx_i),
        .wr_fld_i      (fld_e'(wr_fld_i)),
        .wr_data_i     (wr_data_i),
        .frame_start_i (frame_start),
        .stage_o       (stage),
        .live_o        (live)
    );

    for (genvar g = 0; g < N; g++) begin : g_filt
        // The first byte of a frame already sees the staged settings.
        assign cfg_eff[g] = frame_start ? stage[g] : live[g];
        assign eff_en[g]  = cfg_eff[g].en;
        assign eff_mc[g]  = cfg_eff[g].mcast;

        wkp_filter u_filt (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .beat_i   (beat),
            .cfg_i    (cfg_eff[g]),
            .accept_o (accept[g])
        );
    end

    assign beat_mc = beat.mcast;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            match_q <= '0;
            wake_q  <= 1'b0;
        end else begin
            match_q <= accept;
            wake_q  <= |accept;
        end
    end

    assign match_o = match_q;
    assign wake_o  = wake_q;

endmodule

// File: rtl/wkp_filter_bank_chk.sv
module wkp_filter_bank_chk #(
    parameter int N = 4
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         rx_valid_i,
    input logic         rx_eof_i,
    input logic [N-1:0] match_o,
    input logic         wake_o,
    input logic [N-1:0] eff_en,
    input logic [N-1:0] eff_mc,
    input logic         beat_mc
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (match_o == '0 && !wake_o));

    // R9
    wake_after_eof_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> $past(rx_valid_i && rx_eof_i));

    // R9
    match_drives_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_o != '0) |-> wake_o);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        match_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            match_o[g] |-> $past(eff_en[g]));

        // R6
        addr_class_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            match_o[g] |-> ($past(eff_mc[g]) == $past(beat_mc)));
    end

endmodule

bind wkp_filter_bank wkp_filter_bank_chk #(.N(N)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rx_valid_i (rx_valid_i),
    .rx_eof_i   (rx_eof_i),
    .match_o    (match_o),
    .wake_o     (wake_o),
    .eff_en     (eff_en),
    .eff_mc     (eff_mc),
    .beat_mc    (beat_mc)
);

// File: tb/wkp_filter_bank_tb.sv
module wkp_filter_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic        wr_en;
    logic [1:0]  wr_idx, wr_fld;
    logic [31:0] wr_data;
    logic [3:0]  match_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model of the staged settings.
    logic [30:0] m_mask [4];
    logic [7:0]  m_ofs  [4];
    logic        m_en   [4];
    logic        m_mc   [4];
    logic [15:0] m_crc  [4];

    logic [7:0] fb [64];
    int         flen;

    always #2 clk = ~clk;

    wkp_filter_bank dut_i (
        .clk_i(clk), .rst_i(rst),
        .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_fld_i(wr_fld), .wr_data_i(wr_data),
        .match_o(match_o), .wake_o(wake_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int f);
        logic [15:0] c = 16'hFFFF;
        for (int p = 0; p < flen; p++) begin
            if (p >= m_ofs[f] && p - m_ofs[f] < 31 && m_mask[f][p - m_ofs[f]]) begin
                for (int b = 0; b < 8; b++) begin
                    logic x;
                    x = c[15] ^ fb[p][b];
                    c = {c[14:0], 1'b0};
                    if (x) c = c ^ 16'h8005;
                end
            end
        end
        return c;
    endfunction

    function automatic logic [3:0] ref_hits();
        logic [3:0] h = '0;
        for (int f = 0; f < 4; f++) begin
            int top = -1;
            for (int j = 0; j < 31; j++) if (m_mask[f][j]) top = j;
            h[f] = m_en[f] && (int'(m_ofs[f]) + top < flen) &&
                   (ref_crc(f) == m_crc[f]) && (m_mc[f] == fb[0][0]);
        end
        return h;
    endfunction

    task automatic wr(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_fld = 2'(fld); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (fld)
            0: m_mask[idx] = d[30:0];
            1: m_ofs[idx]  = d[7:0];
            2: begin m_en[idx] = d[0]; m_mc[idx] = d[3]; end
            default: m_crc[idx] = d[15:0];
        endcase
    endtask

    // Program a filter and give it the CRC the current frame produces.
    task automatic arm(input int idx, input int ofs, input logic [31:0] mask, input logic [31:0] cmd);
        wr(idx, 1, 32'(ofs));
        wr(idx, 0, mask);
        wr(idx, 2, cmd);
        wr(idx, 3, {16'h0, ref_crc(idx)});
    endtask

    task automatic fill(input int seed, input logic [7:0] b0, input int len);
        flen = len;
        fb[0] = b0;
        for (int i = 1; i < 64; i++) fb[i] = 8'((seed * 7) + (i * 13) + (i * i));
    endtask

    // Sends the frame; write_at >= 0 places a CRC write for filter 0 on that byte.
    task automatic send(input string tag, input bit gap, input int write_at,
                        input logic [15:0] wval, input logic [3:0] exp);
        for (int i = 0; i < flen; i++) begin
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'hA5;
                wr_en = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == flen - 1); rx_data = fb[i];
            wr_en = (i == write_at);
            wr_idx = 2'd0; wr_fld = 2'd3; wr_data = {16'h0, wval};
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; wr_en = 1'b0;
        check({tag, " match"}, 32'(match_o), 32'(exp));
        check({tag, " wake R9"}, 32'(wake_o), 32'(exp != 0));
        @(negedge clk);
        check({tag, " pulse ends R9"}, {31'(match_o), wake_o}, 32'h0);
    endtask

    task automatic run(input string tag, input logic [3:0] exp_req);
        logic [3:0] exp;
        exp = ref_hits();
        check({tag, " model"}, 32'(exp), 32'(exp_req));
        send(tag, 1'b0, -1, 16'h0, exp);
    endtask

    task automatic t_reset();
        check("R1 reset match", 32'(match_o), 32'h0);
        check("R1 reset wake", 32'(wake_o), 32'h0);
        fill(3, 8'h00, 20);
        run("R1 unconfigured", 4'b0000);
    endtask

    task automatic t_basic();
        fill(1, 8'h02, 40);
        arm(0, 12, 32'h0000_000B, 32'h1);
        run("R3 basic crc", 4'b0001);
    endtask

    task automatic t_mask_select();
        fb[14] ^= 8'h10;
        run("R4 unmasked byte changed", 4'b0001);
        fb[13] ^= 8'h01;
        run("R4 masked byte changed", 4'b0000);
    endtask

    task automatic t_offset_zero();
        fill(9, 8'h44, 16);
        arm(0, 0, 32'h0, 32'h0);
        arm(1, 0, 32'h0000_0001, 32'h1);
        run("R5 offset from first byte", 4'b0010);
        fb[1] ^= 8'hFF;
        run("R5 second byte outside window", 4'b0010);
    endtask

    task automatic t_addr_type();
        fill(5, 8'h01, 30);
        arm(1, 0, 32'h0, 32'h0);
        arm(2, 3, 32'h0000_0007, 32'h9);
        arm(3, 3, 32'h0000_0007, 32'h1);
        run("R6 multicast frame", 4'b0100);
        fb[0] = 8'h00;
        run("R6 unicast frame", 4'b1000);
    endtask

    task automatic t_disabled();
        wr(3, 2, 32'h0);
        run("R2 disabled unicast", 4'b0000);
        wr(3, 2, 32'h8);
        fb[0] = 8'h01;
        run("R2 disabled multicast", 4'b0100);
    endtask

    task automatic t_short();
        fill(11, 8'h06, 40);
        arm(2, 0, 32'h0, 32'h0);
        arm(0, 10, 32'h0010_0001, 32'h1);
        run("R7 full length", 4'b0001);
        flen = 25;
        wr(0, 3, {16'h0, ref_crc(0)});
        run("R7 ends before last masked byte", 4'b0000);
    endtask

    task automatic t_staging();
        logic [3:0] exp;
        fill(13, 8'h08, 24);
        arm(0, 4, 32'h0000_0F0F, 32'h1);
        exp = ref_hits();
        check("R8 model", 32'(exp), 32'h1);
        send("R8 write mid-frame", 1'b0, 6, ~m_crc[0], exp);
        m_crc[0] = ~m_crc[0];
        run("R8 next frame uses write", 4'b0000);
    endtask

    task automatic t_reserved();
        fill(17, 8'h0A, 20);
        arm(0, 0, 32'h0, 32'h0);
        arm(1, 2, 32'h8000_0001, 32'h7);
        run("R10 reserved bits ignored", 4'b0010);
    endtask

    task automatic t_empty_mask();
        fill(19, 8'h03, 12);
        arm(1, 0, 32'h0, 32'h0);
        wr(2, 1, 32'h5);
        wr(2, 0, 32'h0);
        wr(2, 2, 32'h9);
        wr(2, 3, 32'h0000_FFFF);
        run("R11 empty mask", 4'b0100);
    endtask

    task automatic t_gaps();
        logic [3:0] exp;
        fill(23, 8'h04, 36);
        arm(2, 0, 32'h0, 32'h0);
        arm(0, 6, 32'h0550_0A0F, 32'h1);
        exp = ref_hits();
        check("R12 model", 32'(exp), 32'h1);
        send("R12 valid gaps", 1'b1, -1, 16'h0, exp);
    endtask

    task automatic t_all();
        fill(29, 8'h00, 48);
        arm(0, 0,  32'h0000_00FF, 32'h1);
        arm(1, 7,  32'h4000_0001, 32'h1);
        arm(2, 20, 32'h0000_1111, 32'h1);
        arm(3, 33, 32'h0000_0003, 32'h1);
        run("R3 all filters", 4'b1111);
        fb[34] ^= 8'h80;
        run("R4 one filter spoiled", 4'b0111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 4; f++) begin
            m_mask[f] = '0; m_ofs[f] = '0; m_en[f] = 1'b0; m_mc[f] = 1'b0; m_crc[f] = '0;
        end
        rst = 1'b1; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
        wr_en = 1'b0; wr_idx = '0; wr_fld = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mask_select();
        t_offset_zero();
        t_addr_type();
        t_disabled();
        t_short();
        t_staging();
        t_reserved();
        t_empty_mask();
        t_gaps();
        t_all();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule